// File: doc/BRIEF.md
# Operand Address Former

This block turns an operand specifier into either a memory word address or an operand-source selection for a 16-bit processor. The processor addresses memory in 16-bit words, so the space holds 65536 words and neighbouring words sit one address apart. On each request the caller presents a 3-bit mode code, the B register, the frame pointer, a 16-bit extension word and a flag that marks the operand as the target of a jump or call. One clock later the block reports the result on registered outputs.

A memory mode produces a 16-bit word address. Register and immediate modes produce a source selection and no address. The 4K stack window occupies the top of memory. Frame-relative addresses always land inside that window, because the upper nibble is forced to all ones and the low 12 bits wrap. Undefined mode codes are rejected. So is stack mode used as a control-transfer target. A rejected request raises an error output instead of a valid strobe.

Top module: `ea_former`

## Requirements
- R1: During reset and on the first clock after reset, `ea_valid`, `ea_illegal`, `ea_is_mem` and `ea_addr` are all 0.
- R2: A request (`req`=1) sampled on clock edge N produces its results on the outputs after edge N. When `req`=0, `ea_valid` and `ea_illegal` are both 0 on the next cycle.
- R3: Mode 1 (direct) gives `ea_addr` = `ext`, with `ea_is_mem`=1 and `ea_src`=0.
- R4: Mode 2 (indirect) gives `ea_addr` = `b_reg`, with `ea_is_mem`=1 and `ea_src`=0.
- R5: Mode 3 (indexed) gives `ea_addr` = (`b_reg` + `ext`) mod 65536, with `ea_is_mem`=1 and `ea_src`=0.
- R6: Mode 5 (stack) gives `ea_addr[15:12]`=4'hF and `ea_addr[11:0]` = (`fp` + `ext[11:0]`) mod 4096, with `ea_is_mem`=1 and `ea_src`=0.
- R7: Mode 0 (register) gives `ea_is_mem`=0, `ea_addr`=0, and `ea_src`=1 (register operand).
- R8: Mode 4 (immediate) gives `ea_is_mem`=0, `ea_src`=2 (immediate operand), and `ea_imm` = `ext`.
- R9: Modes 6 and 7 give `ea_illegal`=1, `ea_valid`=0, `ea_is_mem`=0, `ea_src`=0 and `ea_addr`=0.
- R10: Mode 5 with `is_ctl`=1 gives `ea_illegal`=1 and `ea_valid`=0. Every other legal mode with `is_ctl`=1 gives `ea_valid`=1, `ea_illegal`=0, and the same result as with `is_ctl`=0.
- R11: `ea_valid` and `ea_illegal` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| is_ctl | input | 1 | Operand is a jump/call target |
| b_reg | input | 16 | B register value |
| fp | input | 12 | Frame pointer |
| ext | input | 16 | Extension word |
| ea_valid | output | 1 | Legal result present |
| ea_illegal | output | 1 | Request rejected |
| ea_is_mem | output | 1 | Result is a memory address |
| ea_src | output | 2 | Operand source: 0 memory/none, 1 register, 2 immediate |
| ea_addr | output | 16 | Word address |
| ea_imm | output | 16 | Immediate operand value |

## Verification
All outputs are registered one stage deep. A wrong mode decode, a lost carry, or a missing stack-nibble force shows up on `ea_addr` or the flags in the cycle after the request. A bad strobe shows in that same cycle as `ea_valid` and `ea_illegal` disagreeing with the mode and control flag. The bench compares every output against its model on every clock, so any divergence is reported at its first cycle. Carry and wrap corners get targeted stimulus, and random traffic covers the rest.

// File: rtl/ea_former.sv
module ea_former #(
  parameter int AW = 16,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic          is_ctl,
  input  logic [AW-1:0] b_reg,
  input  logic [SW-1:0] fp,
  input  logic [AW-1:0] ext,
  output logic          ea_valid,
  output logic          ea_illegal,
  output logic          ea_is_mem,
  output logic [1:0]    ea_src,
  output logic [AW-1:0] ea_addr,
  output logic [AW-1:0] ea_imm
);
  localparam int HW = AW - SW;

  logic          bad, mem;
  logic [1:0]    src;
  logic [AW-1:0] addr;
  logic [SW-1:0] stk_low;

  assign stk_low = fp + ext[SW-1:0];
  assign bad = req & ((mode > 3'd5) | (mode == 3'd5 & is_ctl));

  always_comb begin
    mem  = 1'b0;
    src  = 2'd0;
    addr = '0;
    unique case (mode)
      3'd0: src = 2'd1;
      3'd1: begin mem = 1'b1; addr = ext; end
      3'd2: begin mem = 1'b1; addr = b_reg; end
      3'd3: begin mem = 1'b1; addr = b_reg + ext; end
      3'd4: src = 2'd2;
      3'd5: begin mem = 1'b1; addr = {{HW{1'b1}}, stk_low}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid   <= 1'b0;
      ea_illegal <= 1'b0;
      ea_is_mem  <= 1'b0;
      ea_src     <= 2'd0;
      ea_addr    <= '0;
      ea_imm     <= '0;
    end else begin
      ea_valid   <= req & ~bad;
      ea_illegal <= bad;
      ea_is_mem  <= req & mem;
      ea_src     <= req ? src : 2'd0;
      ea_addr    <= req ? addr : '0;
      ea_imm     <= ext;
    end
  end

  AST_EXCLUSIVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && ea_illegal)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ea_valid && !ea_illegal); // R2
  AST_STACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd5 |=> ea_addr[AW-1:SW] == {HW{1'b1}}); // R6
  AST_CTL_STACK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd5 && is_ctl |=> ea_illegal && !ea_valid); // R10
  AST_UNDEF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode[2:1] == 2'b11 |=> ea_illegal && !ea_is_mem); // R9
  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd1 |=> ea_addr == $past(ext) && ea_is_mem); // R3
  AST_REG_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd0 |=> !ea_is_mem && ea_src == 2'd1); // R7
endmodule

// File: tb/ea_former_tb_top.sv
module ea_former_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, req = 0, is_ctl = 0;
  logic [2:0] mode = 0;
  logic [15:0] b_reg = 0, ext = 0;
  logic [11:0] fp = 0;
  logic ea_valid, ea_illegal, ea_is_mem;
  logic [1:0] ea_src;
  logic [15:0] ea_addr, ea_imm;

  int n_chk = 0, n_fail = 0;
  bit exp_v, exp_i, exp_m;
  int exp_s, exp_a, exp_imm;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_former dut_i (.clk, .rst_n, .req, .mode, .is_ctl, .b_reg, .fp, .ext,
    .ea_valid, .ea_illegal, .ea_is_mem, .ea_src, .ea_addr, .ea_imm);

  task automatic model();
    int m = mode;
    exp_v = 0; exp_i = 0; exp_m = 0; exp_s = 0; exp_a = 0; exp_imm = ext;
    if (!rst_n) begin exp_imm = 0; return; end
    if (!req) return;
    if (m >= 6 || (m == 5 && is_ctl)) begin
      exp_i = 1;
      if (m == 5) begin exp_m = 1; exp_a = 'hF000 + ((fp + ext[11:0]) % 4096); end
      return;
    end
    exp_v = 1;
    case (m)
      0: exp_s = 1;
      1: begin exp_m = 1; exp_a = ext; end
      2: begin exp_m = 1; exp_a = b_reg; end
      3: begin exp_m = 1; exp_a = (b_reg + ext) % 65536; end
      4: exp_s = 2;
      5: begin exp_m = 1; exp_a = 'hF000 + ((fp + ext[11:0]) % 4096); end
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    n_chk++;
    if (ea_valid !== exp_v || ea_illegal !== exp_i || ea_is_mem !== exp_m ||
        ea_src !== 2'(exp_s) || ea_addr !== 16'(exp_a) || ea_imm !== 16'(exp_imm)) begin
      n_fail++;
      $display("FAIL %s: got v=%0b i=%0b m=%0b s=%0d a=%h imm=%h exp v=%0b i=%0b m=%0b s=%0d a=%h imm=%h",
        tag, ea_valid, ea_illegal, ea_is_mem, ea_src, ea_addr, ea_imm,
        exp_v, exp_i, exp_m, exp_s, 16'(exp_a), 16'(exp_imm));
    end
  endtask

  string tag = "R1";
  // Mode code 6/7 must not also raise the memory flag (R9).
  always @(negedge clk) if (!done) begin
    check(tag);
    @(posedge clk); model();
  end

  task automatic drive(bit r, int m, bit c, int b, int f, int e, string t);
    @(negedge clk);
    #1;
    req = r; mode = 3'(m); is_ctl = c; b_reg = 16'(b); fp = 12'(f); ext = 16'(e);
    tag = t;
  endtask

  initial begin
    model();
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    drive(0, 0, 0, 0, 0, 0, "R2");
    drive(1, 1, 0, 0, 0, 'h1234, "R3");
    drive(1, 2, 0, 'hBEEF, 0, 'h1, "R4");
    drive(1, 3, 0, 'hFFFF, 0, 'h0002, "R5");
    drive(1, 3, 0, 'h8000, 0, 'h8000, "R5");
    drive(1, 5, 0, 0, 'hFFE, 'h0005, "R6");
    drive(1, 5, 0, 0, 'h010, 'hABCD, "R6");
    drive(1, 0, 0, 'h5555, 0, 'h7777, "R7");
    drive(1, 4, 0, 0, 0, 'hCAFE, "R8");
    drive(1, 6, 0, 1, 2, 3, "R9");
    drive(1, 7, 1, 1, 2, 3, "R9");
    drive(1, 5, 1, 0, 'h100, 4, "R10");
    drive(1, 3, 1, 'h10, 0, 'h20, "R10");
    drive(1, 4, 1, 0, 0, 'h9, "R10");
    drive(0, 5, 1, 0, 0, 0, "R2");
    for (int k = 0; k < 400; k++)
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
            $urandom, $urandom, $urandom, "R11");
    drive(0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule